// File: doc/BRIEF.md
# Quadrature Step Decoder with Split Direction Counters

The block takes the two phase signals of an incremental rotary or linear encoder. The two phases are square waves a quarter period apart. Which phase leads gives the direction of motion, and the number of edges gives the distance moved. Both phases are brought into the clock domain and each legal change of the two-bit phase state is classified. The block emits a one-cycle pulse on a clockwise output or on a counterclockwise output. This gives four pulses per full encoder cycle.

Each pulse stream feeds its own free-running wrapping counter. A host that wants the net motion raises a read strobe. The block captures both counters in that one cycle and subtracts the copies saved at the previous read. It returns the clockwise gain minus the counterclockwise gain as a signed value, together with a valid flag. A step where both phases flip together cannot be classified. It is dropped and recorded in a sticky error flag, which the next read reports and clears.

Top module: `quad_step_counter`

## Requirements
- R1: A change on the phase inputs passes two synchronizing flops and one decode register, so a resulting step pulse is high in the single cycle after the third rising clock edge that follows the change.
- R2: With the phase state written as {enc_a, enc_b}, the changes 00→10, 10→11, 11→01 and 01→00 each produce exactly one cycle of `cw_step`.
- R3: The reverse changes 10→00, 11→10, 01→11 and 00→01 each produce exactly one cycle of `ccw_step`. `cw_step` and `ccw_step` are never high together.
- R4: While the phase inputs hold still, neither step output pulses.
- R5: A change in which both phases flip at once (00↔11 or 10↔01) produces no step pulse. It sets `seq_err` one cycle after the cycle in which a step pulse would have appeared.
- R6: `seq_err` stays set until a read. A read clears it, unless a new illegal change is flagged in the read cycle, in which case it stays set.
- R7: Each direction counter is CNT_W bits wide (16 by default) and wraps. The delta uses modular subtraction, so a read spanning a counter wrap still returns the true movement.
- R8: `delta_vld` is high for exactly the one cycle after a cycle with `rd_req` high. `delta` then equals (clockwise increase − counterclockwise increase) since the previous read, taken modulo 2^CNT_W as a two's-complement value. `delta` keeps its value between reads.
- R9: A step pulse present in the same cycle as `rd_req` is left out of that read and is counted by the next read.
- R10: `delta_err` shows the value `seq_err` had in the cycle of `rd_req`.
- R11: After reset all outputs are 0 and both counters and both saved copies are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| rd_req | input | 1 | Read strobe for the net movement |
| cw_step | output | 1 | One-cycle pulse per clockwise step |
| ccw_step | output | 1 | One-cycle pulse per counterclockwise step |
| delta | output | CNT_W | Signed net movement since the previous read |
| delta_vld | output | 1 | `delta` and `delta_err` were just updated |
| delta_err | output | 1 | An illegal change occurred in the interval of this read |
| seq_err | output | 1 | Sticky flag for an illegal phase change |

## Verification
The hardest situations to reach are a read that spans a counter wrap and a read strobe that lands in the exact cycle a step pulse leaves the decoder. For the wrap case, the stimulus spins the encoder clockwise 65000 steps without gaps, reads, and then steps a further 1000 so that the counter wraps before the next read. For the coincident case, the stimulus moves the phase by one step and counts three falling edges before raising the strobe, so the strobe is sampled together with the pulse. A behavioural model tracks phase history, counts and saved copies, and is compared with every output on every clock.

// File: rtl/qdec_pkg.sv
// Shared types and the step classification used by the quadrature decoder.
// Assumes the phase state is packed as {phase_a, phase_b}.
package qdec_pkg;

    typedef logic [1:0] phase_t;

    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_CW   = 2'd1,
        MOVE_CCW  = 2'd2,
        MOVE_BAD  = 2'd3
    } move_e;

    // Classify one transition of the two-bit phase state.
    function automatic move_e classify(input phase_t prev, input phase_t cur);
        move_e m;
        case ({prev, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: m = MOVE_CW;
            4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: m = MOVE_CCW;
            default: m = ((prev ^ cur) == 2'b11) ? MOVE_BAD : MOVE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
// Multi-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is sampled on its own. A glitch on a bit is seen as a
// real change, and the decoder downstream flags a change of both bits together.
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift the sampled value one flop further down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[g] <= '0;
            else if (g == 0) stg[g] <= din;
            else             stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/qdec_decode.sv
// Turns synchronized phase states into registered step pulses.
// Assumes the input is already in the clock domain. The first state after
// reset is compared against 00.
module qdec_decode
    import qdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t cur_st,
    output phase_t prev_st,
    output logic   cw_step,
    output logic   ccw_step,
    output logic   bad_step
);
    move_e mv;

    // Classify the change between the stored and current state.
    always_comb mv = classify(prev_st, cur_st);

    // Remember the state and register the classified pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_st  <= '0;
            cw_step  <= 1'b0;
            ccw_step <= 1'b0;
            bad_step <= 1'b0;
        end else begin
            prev_st  <= cur_st;
            cw_step  <= (mv == MOVE_CW);
            ccw_step <= (mv == MOVE_CCW);
            bad_step <= (mv == MOVE_BAD);
        end
    end
endmodule

// File: rtl/qdec_counter.sv
// Free-running wrapping pulse counter.
// Assumes at most one increment per cycle.
module qdec_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Add one for each pulse and let the count wrap at 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qdec_reader.sv
// Read port: saves both counters on a read and returns their net difference.
// It also keeps the sticky illegal-transition flag.
// Assumes the counters are the registered values. A pulse in the read cycle
// therefore lands in the counter after the copy is taken.
module qdec_reader #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                bad_step,
    input  logic [W-1:0]        cw_cnt,
    input  logic [W-1:0]        ccw_cnt,
    output logic signed [W-1:0] delta,
    output logic                delta_vld,
    output logic                delta_err,
    output logic                seq_err
);
    logic [W-1:0] cw_snap, ccw_snap;
    logic [W-1:0] cw_gain, ccw_gain, net;

    // Modular gains since the last read and their difference.
    always_comb begin
        cw_gain  = cw_cnt - cw_snap;
        ccw_gain = ccw_cnt - ccw_snap;
        net      = cw_gain - ccw_gain;
    end

    // Capture both counters together and publish the difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_snap   <= '0;
            ccw_snap  <= '0;
            delta     <= '0;
            delta_vld <= 1'b0;
            delta_err <= 1'b0;
        end else begin
            delta_vld <= rd_req;
            if (rd_req) begin
                cw_snap   <= cw_cnt;
                ccw_snap  <= ccw_cnt;
                delta     <= $signed(net);
                delta_err <= seq_err;
            end
        end
    end

    // Sticky error: set by an illegal change, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      seq_err <= 1'b0;
        else if (rd_req) seq_err <= bad_step;
        else             seq_err <= seq_err | bad_step;
    end
endmodule

// File: rtl/quad_step_counter.sv
// Quadrature decoder top: synchronizer, step decoder, one counter per
// direction, and the read port that returns net movement.
// Assumes the encoder phases are asynchronous and that each phase changes
// at most once every few clock cycles.
module quad_step_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic                    rd_req,
    output logic                    cw_step,
    output logic                    ccw_step,
    output logic signed [CNT_W-1:0] delta,
    output logic                    delta_vld,
    output logic                    delta_err,
    output logic                    seq_err
);
    localparam int NDIR = 2;

    phase_t cur_st, prev_st;
    logic   bad_step;
    logic [NDIR-1:0]            dir_pulse;
    logic [NDIR-1:0][CNT_W-1:0] dir_cnt;
    logic [CNT_W-1:0]           cw_cnt, ccw_cnt;

    qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({enc_a, enc_b}), .dout(cur_st)
    );

    qdec_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cur_st(cur_st), .prev_st(prev_st),
        .cw_step(cw_step), .ccw_step(ccw_step), .bad_step(bad_step)
    );

    assign dir_pulse = {ccw_step, cw_step};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        qdec_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(dir_pulse[d]), .cnt(dir_cnt[d])
        );
    end

    assign cw_cnt  = dir_cnt[0];
    assign ccw_cnt = dir_cnt[1];

    qdec_reader #(.W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .bad_step(bad_step),
        .cw_cnt(cw_cnt), .ccw_cnt(ccw_cnt), .delta(delta),
        .delta_vld(delta_vld), .delta_err(delta_err), .seq_err(seq_err)
    );
endmodule

// File: rtl/qdec_checker.sv
// Temporal checks on the quadrature decoder, bound to the top module.
module qdec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             cw_step,
    input logic             ccw_step,
    input logic [CNT_W-1:0] delta,
    input logic             delta_vld,
    input logic             seq_err,
    input logic [1:0]       cur_st,
    input logic [1:0]       prev_st,
    input logic [CNT_W-1:0] cw_cnt
);
    // R3: the two directions are exclusive
    a_r3_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cw_step, ccw_step}));

    // R5: a double flip yields no pulse
    a_r5_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_st ^ prev_st) == 2'b11) |=> (!cw_step && !ccw_step));

    // R5: a double flip sets the sticky flag two cycles later
    a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_st ^ prev_st) == 2'b11) |=> ##1 seq_err);

    // R6: the flag holds until a read
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !rd_req) |=> seq_err);

    // R7: the counter advances by one per clockwise pulse
    a_r7_cnt_inc: assert property (@(posedge clk) disable iff (!rst_n)
        cw_step |=> (cw_cnt == CNT_W'($past(cw_cnt) + 1'b1)));

    // R7: the counter holds without a pulse
    a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_step |=> $stable(cw_cnt));

    // R8: valid follows the strobe by one cycle
    a_r8_vld: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> delta_vld);

    // R8: no strobe, no valid, and delta holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!delta_vld && $stable(delta)));
endmodule

bind quad_step_counter qdec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cw_step(cw_step),
    .ccw_step(ccw_step), .delta(delta), .delta_vld(delta_vld),
    .seq_err(seq_err), .cur_st(cur_st), .prev_st(prev_st), .cw_cnt(cw_cnt)
);

// File: tb/sim_quad_step_counter.sv
module sim_quad_step_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, rd_req = 1'b0;
    logic cw_step, ccw_step, delta_vld, delta_err, seq_err;
    logic signed [15:0] delta;

    int checks = 0;
    int failures = 0;
    int pos = 0;

    quad_step_counter u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .rd_req(rd_req), .cw_step(cw_step), .ccw_step(ccw_step),
        .delta(delta), .delta_vld(delta_vld), .delta_err(delta_err),
        .seq_err(seq_err)
    );

    always #5 clk = ~clk;

    // Gray position order for clockwise motion, state = {a,b}
    function automatic logic [1:0] st_of(int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int pos_of(logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    logic [1:0] m_s1 = 0, m_s2 = 0, m_pv = 0;
    bit e_cw = 0, e_ccw = 0, e_bad = 0, e_err = 0, e_vld = 0, e_derr = 0;
    int m_cw = 0, m_ccw = 0, k_cw = 0, k_ccw = 0;
    logic [15:0] e_delta = 0;

    // Model update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pv = 0;
            e_cw = 0; e_ccw = 0; e_bad = 0; e_err = 0; e_vld = 0; e_derr = 0;
            m_cw = 0; m_ccw = 0; k_cw = 0; k_ccw = 0; e_delta = 0;
        end else begin
            int d;
            bit n_cw, n_ccw, n_bad;
            d = (pos_of(m_s2) - pos_of(m_pv)) & 3;
            n_cw = (d == 1); n_ccw = (d == 3); n_bad = (d == 2);
            if (rd_req) begin
                e_delta = 16'(((m_cw - k_cw) - (m_ccw - k_ccw)) & 16'hFFFF);
                k_cw = m_cw; k_ccw = m_ccw;
                e_derr = e_err;
                e_err = e_bad;
            end else begin
                e_err = e_err | e_bad;
            end
            e_vld = rd_req;
            m_cw = (m_cw + int'(e_cw)) & 16'hFFFF;
            m_ccw = (m_ccw + int'(e_ccw)) & 16'hFFFF;
            e_cw = n_cw; e_ccw = n_ccw; e_bad = n_bad;
            m_pv = m_s2; m_s2 = m_s1; m_s1 = {enc_a, enc_b};
        end
    end

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cw_step === e_cw, "R2 cw_step", cw_step, e_cw);
            chk(ccw_step === e_ccw, "R3 ccw_step", ccw_step, e_ccw);
            chk(seq_err === e_err, "R6 seq_err", seq_err, e_err);
            chk(delta_vld === e_vld, "R8 delta_vld", delta_vld, e_vld);
            chk(delta === e_delta, "R8 delta", delta, e_delta);
            chk(delta_err === e_derr, "R10 delta_err", delta_err, e_derr);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic move(input int step);
        @(negedge clk);
        pos = pos + step;
        {enc_a, enc_b} = st_of(pos);
    endtask

    task automatic spin(input int n, input bit ccw, input int gap);
        for (int i = 0; i < n; i++) begin
            move(ccw ? 3 : 1);
            idle(gap);
        end
    endtask

    task automatic rd(output int d, output bit de);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        d = int'(delta);
        de = delta_err;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d;
        bit de;
        int pulses;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk({cw_step, ccw_step, delta_vld, delta_err, seq_err} == 0, "R11 flags", 0, 0);
        chk(delta == 0, "R11 delta", delta, 0);

        // R1: pulse latency of three edges
        move(1);
        @(negedge clk); chk(cw_step == 0, "R1 edge1", cw_step, 0);
        @(negedge clk); chk(cw_step == 0, "R1 edge2", cw_step, 0);
        @(negedge clk); chk(cw_step == 1, "R1 edge3", cw_step, 1);
        @(negedge clk); chk(cw_step == 0, "R1 edge4", cw_step, 0);

        // R2: clockwise steps with gaps
        spin(10, 0, 2); idle(4); rd(d, de);
        chk(d == 11, "R2 cw delta", d, 11);

        // R3: counterclockwise steps
        spin(25, 1, 1); idle(4); rd(d, de);
        chk(d == -25, "R3 ccw delta", d, -25);

        // R8: mixed motion
        spin(7, 0, 0); spin(3, 1, 3); idle(4); rd(d, de);
        chk(d == 4, "R8 mixed delta", d, 4);

        // R4: still inputs give no pulses
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pulses += int'(cw_step) + int'(ccw_step);
        end
        chk(pulses == 0, "R4 still", pulses, 0);

        // R5: double flip gives no pulse and sets the error
        move(2); idle(6);
        chk(seq_err == 1, "R5 seq_err", seq_err, 1);
        rd(d, de);
        chk(d == 0, "R5 no motion", d, 0);
        chk(de == 1, "R10 delta_err", de, 1);
        idle(1);
        chk(seq_err == 0, "R6 cleared", seq_err, 0);

        // R6: flag persists without a read
        move(2); idle(30);
        chk(seq_err == 1, "R6 persists", seq_err, 1);
        rd(d, de); idle(2);

        // R9: pulse in the read cycle goes to the next read
        move(1);
        repeat (3) @(negedge clk);
        chk(cw_step == 1, "R9 pulse present", cw_step, 1);
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        chk(delta == 0, "R9 first read", delta, 0);
        idle(2); rd(d, de);
        chk(d == 1, "R9 second read", d, 1);

        // R7: reads across a counter wrap
        spin(65000, 0, 0); idle(4); rd(d, de);
        spin(1000, 0, 0); idle(4); rd(d, de);
        chk(d == 1000, "R7 wrap delta", d, 1000);
        spin(300, 1, 0); idle(4); rd(d, de);
        chk(d == -300, "R7 ccw after wrap", d, -300);

        idle(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule